// File: doc/BRIEF.md
# Performance Counter CSR Bank

This block holds 29 general-purpose 64-bit event counters, numbered 3 through 31, and one event-selector register for each. A processor's CSR unit reaches them through a plain request port: a 12-bit CSR address, a write strobe and write data whose width is the register width parameter `XLEN` (32 or 64). The block decodes four counter address windows and the event-selector window. It also holds the three counter control registers: machine counter-enable, supervisor counter-enable and counter-inhibit. It drives their legalized values out to the privilege-check logic. Privilege checks and the fixed cycle, time and retired-instruction counters are outside this block.

A 32-bit platform strap, `impl_mask_i`, names the counters that exist. A counter whose bit is clear never counts. Writes to it, to its high half or to its selector are dropped, so it reads 0. Each implemented counter adds one on every cycle its event input is high, unless its inhibit bit is set. A software write in the same cycle replaces the counter and suppresses that increment. Read results come back one cycle after the request.

Top module: `hpm_csr_bank`

## Requirements
- R1: The machine counter window is the address `0xB00 | n` with index n in 3..31 (address bits 11:5 equal 7'b1011000). A read returns counter bits XLEN-1:0. A write replaces exactly those bits.
- R2: When XLEN is 32, the address `0xB80 | n` (bits 11:5 equal 7'b1011100, n >= 3) reads and writes counter bits 63:32. When XLEN is 64, these addresses are out of range.
- R3: The user shadow addresses `0xC00 | n` and, with XLEN 32 only, `0xC80 | n` (n >= 3) return the same value as the matching machine address. Writes to them change nothing.
- R4: The event selector for counter n sits at `0x320 | n` (n >= 3). It is XLEN bits wide and reads back what was written.
- R5: A write to a counter low half, counter high half or event selector whose index bit in `impl_mask_i` is 0 is dropped. The register keeps reading its old value, which is 0 because of R11.
- R6: A write to address `0x306` (machine enable) or `0x106` (supervisor enable) stores the write data ANDed with `{impl_mask_i[31:3], 3'b111}`. The stored value is driven on `mcounten_o` / `scounten_o` and is returned by reads of the same address.
- R7: A write to address `0x320` (inhibit) stores the write data ANDed with `{impl_mask_i[31:3], 3'b101}`. Bit 1 therefore always reads 0. The stored value is driven on `inhibit_o` and is returned by reads.
- R8: Counter n adds 1 at each clock edge where `event_i[n]` is 1, `impl_mask_i[n]` is 1 and `inhibit_o[n]` is 0. The carry runs across all 64 bits.
- R9: A write to a counter half in the same cycle as its event replaces the written bits with the write data. No increment is applied in that cycle.
- R10: A read request (`csr_req_i` high, `csr_we_i` low) gives `rsp_valid_o` high on the next cycle, together with `rsp_data_o` and `rsp_oor_o`. Write requests give no response. An index below 3 in a counter or selector window, or any address outside all windows, reads as data 0 with `rsp_oor_o` set to 1.
- R11: After reset, every counter, every event selector and all three control registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_req_i | input | 1 | Access request, one cycle per access |
| csr_we_i | input | 1 | 1 = write, 0 = read |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | Write data |
| impl_mask_i | input | 32 | Platform strap: bit n = counter n implemented and writable; bits 2:0 unused |
| event_i | input | 32 | Per-counter event pulses; bits 2:0 unused |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_data_o | output | XLEN | Read response data |
| rsp_oor_o | output | 1 | Read address was out of range |
| mcounten_o | output | 32 | Legalized machine counter-enable |
| scounten_o | output | 32 | Legalized supervisor counter-enable |
| inhibit_o | output | 32 | Legalized counter-inhibit |

## Verification
Counting is tried with several event patterns. The first is a multi-cycle burst on an enabled counter, which must advance by exactly the burst length. The same burst on an unimplemented counter must leave it at 0, and a burst on an inhibited counter must leave it unchanged. Three more cases follow. An event that lands in the same cycle as a write must be lost to the write, and a single event on a low half of all ones must carry into the high half. An all-ones write to each control register shows the exact legalizing pattern, and the strap is chosen with holes at indices 3 and 7 so that dropped writes and forced-low bits stand apart from normal ones. A second instance at XLEN 64 separates full-width low writes from the high-half window, which is absent there.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    localparam int unsigned NUM_IDX   = 32;
    localparam int unsigned FIRST_IDX = 3;
    localparam int unsigned CNT_W     = 64;

    typedef enum logic [3:0] {
        WIN_NONE,
        WIN_MCNT_LO,
        WIN_MCNT_HI,
        WIN_UCNT_LO,
        WIN_UCNT_HI,
        WIN_EVSEL,
        WIN_MEN,
        WIN_SEN,
        WIN_INH
    } hpm_win_e;

    // enable registers keep cycle/time/instret bits writable
    function automatic logic [31:0] legal_enable(logic [31:0] v, logic [28:0] m);
        return v & {m, 3'b111};
    endfunction

    // inhibit register: the time bit (bit 1) can never be set
    function automatic logic [31:0] legal_inhibit(logic [31:0] v, logic [28:0] m);
        return v & {m, 3'b101};
    endfunction

endpackage

// File: rtl/hpm_addr_decode.sv
module hpm_addr_decode
    import hpm_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [11:0] addr_i,
    output hpm_win_e    win_o,
    output logic [4:0]  idx_o
);

    localparam bit HAS_HI = (XLEN == 32);

    logic [6:0] page;
    logic [4:0] idx;
    logic       idx_ok;

    assign page   = addr_i[11:5];
    assign idx    = addr_i[4:0];
    assign idx_ok = (idx >= 5'(FIRST_IDX));
    assign idx_o  = idx;

    always_comb begin
        win_o = WIN_NONE;
        unique case (page)
            7'b1011000: if (idx_ok) win_o = WIN_MCNT_LO;
            7'b1011100: if (idx_ok && HAS_HI) win_o = WIN_MCNT_HI;
            7'b1100000: if (idx_ok) win_o = WIN_UCNT_LO;
            7'b1100100: if (idx_ok && HAS_HI) win_o = WIN_UCNT_HI;
            7'b0011001: begin
                if (idx_ok)           win_o = WIN_EVSEL;
                else if (idx == 5'd0) win_o = WIN_INH;
            end
            7'b0011000: if (idx == 5'd6) win_o = WIN_MEN;
            7'b0001000: if (idx == 5'd6) win_o = WIN_SEN;
            default:    win_o = WIN_NONE;
        endcase
    end

endmodule

// File: rtl/hpm_ctrl_regs.sv
module hpm_ctrl_regs
    import hpm_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_men_i,
    input  logic        wr_sen_i,
    input  logic        wr_inh_i,
    input  logic [31:0] wdata_i,
    input  logic [28:0] impl_i,
    output logic [31:0] men_o,
    output logic [31:0] sen_o,
    output logic [31:0] inh_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            men_o <= '0;
            sen_o <= '0;
            inh_o <= '0;
        end else begin
            if (wr_men_i) men_o <= legal_enable(wdata_i, impl_i);
            if (wr_sen_i) sen_o <= legal_enable(wdata_i, impl_i);
            if (wr_inh_i) inh_o <= legal_inhibit(wdata_i, impl_i);
        end
    end

endmodule

// File: rtl/hpm_counter_slot.sv
module hpm_counter_slot
    import hpm_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             impl_i,
    input  logic             inhibit_i,
    input  logic             event_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic             wr_sel_i,
    input  logic [XLEN-1:0]  wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [XLEN-1:0]  sel_o
);

    logic [CNT_W-1:0] wr_val;
    logic             do_wr;
    logic             do_inc;

    assign do_wr  = impl_i && (wr_lo_i || wr_hi_i);
    assign do_inc = impl_i && !inhibit_i && event_i;

    always_comb begin
        wr_val = cnt_o;
        if (wr_lo_i) wr_val[XLEN-1:0] = wdata_i;
        if (wr_hi_i) wr_val[63:32]    = wdata_i[31:0];
    end

    // software write wins over a same-cycle event
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_o <= '0;
        else if (do_wr)  cnt_o <= wr_val;
        else if (do_inc) cnt_o <= cnt_o + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   sel_o <= '0;
        else if (impl_i && wr_sel_i)   sel_o <= wdata_i;
    end

endmodule

// File: rtl/hpm_csr_bank.sv
module hpm_csr_bank
    import hpm_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            csr_req_i,
    input  logic            csr_we_i,
    input  logic [11:0]     csr_addr_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    input  logic [31:0]     impl_mask_i,
    input  logic [31:0]     event_i,
    output logic            rsp_valid_o,
    output logic [XLEN-1:0] rsp_data_o,
    output logic            rsp_oor_o,
    output logic [31:0]     mcounten_o,
    output logic [31:0]     scounten_o,
    output logic [31:0]     inhibit_o
);

    hpm_win_e   win;
    logic [4:0] idx;
    logic       wr;
    logic       rd;

    logic [CNT_W-1:0] cnt_q [NUM_IDX];
    logic [XLEN-1:0]  sel_q [NUM_IDX];

    logic [XLEN-1:0] rd_val;
    logic            rd_oor;

    logic unused_low;
    assign unused_low = ^{impl_mask_i[2:0], event_i[2:0]};

    assign wr = csr_req_i &&  csr_we_i;
    assign rd = csr_req_i && !csr_we_i;

    hpm_addr_decode #(.XLEN(XLEN)) u_dec (
        .addr_i (csr_addr_i),
        .win_o  (win),
        .idx_o  (idx)
    );

    hpm_ctrl_regs u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_men_i (wr && (win == WIN_MEN)),
        .wr_sen_i (wr && (win == WIN_SEN)),
        .wr_inh_i (wr && (win == WIN_INH)),
        .wdata_i  (csr_wdata_i[31:0]),
        .impl_i   (impl_mask_i[31:3]),
        .men_o    (mcounten_o),
        .sen_o    (scounten_o),
        .inh_o    (inhibit_o)
    );

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_slot
        if (g >= FIRST_IDX) begin : g_impl
            logic hit;
            assign hit = (idx == 5'(g));
            hpm_counter_slot #(.XLEN(XLEN)) u_slot (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .impl_i    (impl_mask_i[g]),
                .inhibit_i (inhibit_o[g]),
                .event_i   (event_i[g]),
                .wr_lo_i   (wr && hit && (win == WIN_MCNT_LO)),
                .wr_hi_i   (wr && hit && (win == WIN_MCNT_HI)),
                .wr_sel_i  (wr && hit && (win == WIN_EVSEL)),
                .wdata_i   (csr_wdata_i),
                .cnt_o     (cnt_q[g]),
                .sel_o     (sel_q[g])
            );
        end else begin : g_fixed
            assign cnt_q[g] = '0;
            assign sel_q[g] = '0;
        end
    end

    always_comb begin
        rd_val = '0;
        rd_oor = 1'b0;
        unique case (win)
            WIN_MCNT_LO, WIN_UCNT_LO: rd_val = cnt_q[idx][XLEN-1:0];
            WIN_MCNT_HI, WIN_UCNT_HI: rd_val = XLEN'(cnt_q[idx][63:32]);
            WIN_EVSEL:                rd_val = sel_q[idx];
            WIN_MEN:                  rd_val = XLEN'(mcounten_o);
            WIN_SEN:                  rd_val = XLEN'(scounten_o);
            WIN_INH:                  rd_val = XLEN'(inhibit_o);
            default:                  rd_oor = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
            rsp_oor_o   <= 1'b0;
        end else begin
            rsp_valid_o <= rd;
            if (rd) begin
                rsp_data_o <= rd_val;
                rsp_oor_o  <= rd_oor;
            end
        end
    end

endmodule

// File: rtl/hpm_csr_bank_chk.sv
module hpm_csr_bank_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            req,
    input logic            we,
    input logic [11:0]     addr,
    input logic [31:0]     wdata,
    input logic [28:0]     mask,
    input logic            rsp_valid,
    input logic [XLEN-1:0] rsp_data,
    input logic            rsp_oor,
    input logic [31:0]     men,
    input logic [31:0]     inh
);

    a_r10_read_gets_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req && !we) |=> rsp_valid);

    a_r10_no_spurious_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req && !we) |=> !rsp_valid);

    a_r10_oor_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid && rsp_oor) |-> (rsp_data == '0));

    a_r6_menable_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req && we && addr == 12'h306) |=> (men == ($past(wdata) & {$past(mask), 3'b111})));

    a_r6_menable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req && we && addr == 12'h306) |=> $stable(men));

    a_r7_inhibit_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req && we && addr == 12'h320) |=> (inh == ($past(wdata) & {$past(mask), 3'b101})));

    a_r7_inhibit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req && we && addr == 12'h320) |=> $stable(inh));

endmodule

bind hpm_csr_bank hpm_csr_bank_chk #(.XLEN(XLEN)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req       (csr_req_i),
    .we        (csr_we_i),
    .addr      (csr_addr_i),
    .wdata     (csr_wdata_i[31:0]),
    .mask      (impl_mask_i[31:3]),
    .rsp_valid (rsp_valid_o),
    .rsp_data  (rsp_data_o),
    .rsp_oor   (rsp_oor_o),
    .men       (mcounten_o),
    .inh       (inhibit_o)
);

// File: tb/hpm_csr_bank_tb_top.sv
`timescale 1ns/1ps
module hpm_csr_bank_tb_top;

    localparam logic [31:0] MASK = 32'hFFFF_FF70; // indices 3 and 7 absent

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // XLEN = 32 instance
    logic        req = 0, we = 0;
    logic [11:0] addr = '0;
    logic [31:0] wd = '0;
    logic [31:0] ev = '0;
    logic        rv, oor;
    logic [31:0] rdat, men, sen, inh;

    hpm_csr_bank #(.XLEN(32)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req), .csr_we_i(we),
        .csr_addr_i(addr), .csr_wdata_i(wd), .impl_mask_i(MASK), .event_i(ev),
        .rsp_valid_o(rv), .rsp_data_o(rdat), .rsp_oor_o(oor),
        .mcounten_o(men), .scounten_o(sen), .inhibit_o(inh)
    );

    // XLEN = 64 instance
    logic        req64 = 0, we64 = 0;
    logic [11:0] addr64 = '0;
    logic [63:0] wd64 = '0;
    logic        rv64, oor64;
    logic [63:0] rdat64;
    logic [31:0] men64, sen64, inh64;

    hpm_csr_bank #(.XLEN(64)) dut64_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req64), .csr_we_i(we64),
        .csr_addr_i(addr64), .csr_wdata_i(wd64), .impl_mask_i(32'hFFFF_FFFF),
        .event_i(32'h0), .rsp_valid_o(rv64), .rsp_data_o(rdat64), .rsp_oor_o(oor64),
        .mcounten_o(men64), .scounten_o(sen64), .inhibit_o(inh64)
    );

    int    tests = 0;
    int    fails = 0;
    bit    done  = 0;

    logic [31:0] exp_d_q [$];
    logic        exp_o_q [$];
    string       tag_q   [$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: scoreboard entry pushed before the request goes out
    task automatic rd32(input logic [11:0] a, input logic [31:0] ed, input logic eo, input string tag);
        exp_d_q.push_back(ed);
        exp_o_q.push_back(eo);
        tag_q.push_back(tag);
        req = 1; we = 0; addr = a;
        @(negedge clk);
        req = 0;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        req = 1; we = 1; addr = a; wd = d;
        @(negedge clk);
        req = 0; we = 0;
    endtask

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && rv) begin
            if (tag_q.size() == 0) begin
                check("R10 unexpected response", 64'(rdat), 64'hX);
            end else begin
                string       t;
                logic [31:0] d;
                logic        o;
                t = tag_q.pop_front();
                d = exp_d_q.pop_front();
                o = exp_o_q.pop_front();
                check({t, " data"}, 64'(rdat), 64'(d));
                check({t, " oor"},  64'(oor),  64'(o));
            end
        end
    end

    task automatic wr64(input logic [11:0] a, input logic [63:0] d);
        req64 = 1; we64 = 1; addr64 = a; wd64 = d;
        @(negedge clk);
        req64 = 0; we64 = 0;
    endtask

    task automatic rd64(input logic [11:0] a, input logic [63:0] ed, input logic eo, input string tag);
        req64 = 1; we64 = 0; addr64 = a;
        @(negedge clk);
        req64 = 0;
        check({tag, " valid"}, 64'(rv64), 64'd1);
        check({tag, " data"},  rdat64, ed);
        check({tag, " oor"},   64'(oor64), 64'(eo));
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        check("R11 mcounten reset", 64'(men), 64'h0);
        check("R11 scounten reset", 64'(sen), 64'h0);
        check("R11 inhibit reset",  64'(inh), 64'h0);
        rd32(12'hB05, 32'h0, 1'b0, "R11 counter reset");
        rd32(12'h325, 32'h0, 1'b0, "R11 selector reset");

        // R1 low half
        wr32(12'hB05, 32'h1234_5678);
        rd32(12'hB05, 32'h1234_5678, 1'b0, "R1 low write/read");

        // R2 high half on XLEN 32
        wr32(12'hB85, 32'hCAFE_0001);
        rd32(12'hB85, 32'hCAFE_0001, 1'b0, "R2 high write/read");
        rd32(12'hB05, 32'h1234_5678, 1'b0, "R2 low untouched by high write");

        // R3 user shadows
        rd32(12'hC05, 32'h1234_5678, 1'b0, "R3 shadow low");
        rd32(12'hC85, 32'hCAFE_0001, 1'b0, "R3 shadow high");
        wr32(12'hC05, 32'h0);
        wr32(12'hC85, 32'h0);
        rd32(12'hB05, 32'h1234_5678, 1'b0, "R3 shadow write ignored low");
        rd32(12'hB85, 32'hCAFE_0001, 1'b0, "R3 shadow write ignored high");

        // R4 event selectors
        wr32(12'h326, 32'hA5A5_0F0F);
        rd32(12'h326, 32'hA5A5_0F0F, 1'b0, "R4 selector write/read");
        rd32(12'h32F, 32'h0, 1'b0, "R4 neighbour selector untouched");

        // R5 unimplemented indices 3 and 7
        wr32(12'hB03, 32'h0000_FFFF);
        rd32(12'hB03, 32'h0, 1'b0, "R5 dropped low write");
        wr32(12'hB87, 32'h0000_00AA);
        rd32(12'hB87, 32'h0, 1'b0, "R5 dropped high write");
        wr32(12'h327, 32'h0000_0001);
        rd32(12'h327, 32'h0, 1'b0, "R5 dropped selector write");

        // R10 out of range
        rd32(12'hB01, 32'h0, 1'b1, "R10 counter index below 3");
        rd32(12'h321, 32'h0, 1'b1, "R10 selector index 1");
        rd32(12'hC02, 32'h0, 1'b1, "R10 shadow index 2");
        rd32(12'h123, 32'h0, 1'b1, "R10 unknown address");

        // R6 enable legalization
        wr32(12'h306, 32'hFFFF_FFFF);
        check("R6 mcounten legalized", 64'(men), 64'hFFFF_FF77);
        rd32(12'h306, 32'hFFFF_FF77, 1'b0, "R6 mcounten readback");
        wr32(12'h106, 32'h0000_00F2);
        check("R6 scounten legalized", 64'(sen), 64'h0000_0072);
        rd32(12'h106, 32'h0000_0072, 1'b0, "R6 scounten readback");

        // R7 inhibit legalization
        wr32(12'h320, 32'hFFFF_FFFF);
        check("R7 inhibit legalized", 64'(inh), 64'hFFFF_FF75);
        rd32(12'h320, 32'hFFFF_FF75, 1'b0, "R7 inhibit readback");
        wr32(12'h320, 32'h0);

        // R8 counting: 5-cycle burst on 6 (enabled) and 3 (absent)
        ev[6] = 1; ev[3] = 1;
        repeat (5) @(negedge clk);
        ev = '0;
        rd32(12'hB06, 32'd5, 1'b0, "R8 burst of five");
        rd32(12'hB03, 32'd0, 1'b0, "R8 absent counter holds");
        wr32(12'h320, 32'h0000_0040);
        ev[6] = 1; ev[4] = 1;
        repeat (3) @(negedge clk);
        ev = '0;
        rd32(12'hB06, 32'd5, 1'b0, "R8 inhibited counter holds");
        rd32(12'hB04, 32'd3, 1'b0, "R8 neighbour counts while other inhibited");

        // R9 write beats event in the same cycle
        ev[8] = 1;
        wr32(12'hB08, 32'd100);
        ev = '0;
        rd32(12'hB08, 32'd100, 1'b0, "R9 write wins over event");

        // R8 carry into upper half
        wr32(12'hB09, 32'hFFFF_FFFF);
        wr32(12'hB89, 32'h0);
        ev[9] = 1;
        @(negedge clk);
        ev = '0;
        rd32(12'hB09, 32'h0, 1'b0, "R8 carry low half");
        rd32(12'hB89, 32'h1, 1'b0, "R8 carry high half");

        // XLEN 64 instance: R1 full width, R3 shadow, R2 window absent
        wr64(12'hB0A, 64'h0123_4567_89AB_CDEF);
        rd64(12'hB0A, 64'h0123_4567_89AB_CDEF, 1'b0, "R1 64-bit low write");
        rd64(12'hC0A, 64'h0123_4567_89AB_CDEF, 1'b0, "R3 64-bit shadow");
        rd64(12'hB8A, 64'h0, 1'b1, "R2 high window absent at XLEN 64");
        rd64(12'hC8A, 64'h0, 1'b1, "R2 shadow high absent at XLEN 64");

        repeat (3) @(negedge clk);
        check("R10 all responses received", 64'(tag_q.size()), 64'd0);
        done = 1;
        finish_run();
    end

endmodule